// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block sits between a synchronous client and a 16-bit asynchronous static RAM with a 17-bit word address and separate lower and upper byte strobes. A client raises a one-cycle request with an address, a data word and a two-bit lane mask. The sequencer then runs one complete, correctly timed write on the memory pins. It raises busy for the whole write and gives a one-cycle done pulse when the memory may accept a new address.

Every timing limit is a nanosecond parameter. The limits are the write pulse width, the address-to-window-end time, the data-to-window-end time, the full cycle time and the output-enable recovery. Each is turned into whole clocks by ceiling division against a clock-period parameter, with a floor of one clock. The write window is the interval in which chip select, write enable and at least one lane strobe are all low. The sequencer opens chip select, the lane strobes, the address and the data one clock before write enable falls. It lifts write enable one clock before the others, so write enable alone marks where the window begins and ends.

Output enable stays high at all times, because the block only writes. The data bus driver is enabled only while chip select is low.

Top module: `sram_wr_seq`

## Requirements
- R1: While reset is held, and after it until the first request, chip select, write enable, both lane strobes and output enable are high, the data driver enable is low, and busy and done are low.
- R2: A request with a nonzero lane mask taken while busy is low is accepted at the next edge. In the following cycle busy is high, chip select is low, write enable is high, and the address and data are driven. The lower strobe is low exactly when mask bit 0 is set, and that lane covers data bits 7:0. The upper strobe is low exactly when mask bit 1 is set, and that lane covers data bits 15:8. Memory bytes on disabled lanes keep their old value.
- R3: Write enable stays low for P consecutive cycles, where P is the largest of ceil(tWP/Tclk), ceil(tAW/Tclk)-1, ceil(tDW/Tclk)-1 and 1. With the defaults (10 ns clock, 45/50/25 ns) P is 5.
- R4: Write enable falls only after chip select, the active strobes and the data driver have been low, low and on for a full cycle. It rises while they are still asserted, and they stay asserted for one more hold cycle. Address and data are therefore present for at least ceil(tAW/Tclk) and ceil(tDW/Tclk) cycles before the window ends.
- R5: The data driver enable is high only while chip select is low. The address output does not change while busy stays high.
- R6: Busy stays high for 2+P+R cycles. R is the largest of ceil(tWC/Tclk)-P-2, ceil(tOW/Tclk) and 1. During the R recovery cycles chip select, the strobes and write enable are high and the driver is off. With the defaults the total is 8.
- R7: Done is high for exactly one cycle, the first cycle in which busy is low again. A request presented in that same cycle is accepted.
- R8: A request that arrives while busy is high is ignored: the address pins keep the current address and no extra write or done follows. A request whose lane mask is zero is ignored: busy stays low and chip select stays high.
- R9: Output enable is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | One-cycle write request |
| addr_i | input | 17 | Word address of the request |
| data_i | input | 16 | Write data of the request |
| be_i | input | 2 | Lane mask; bit 0 lower byte, bit 1 upper byte |
| busy_o | output | 1 | A write is in progress |
| done_o | output | 1 | One-cycle pulse when the write cycle has ended |
| mem_addr_o | output | 17 | Memory address pins |
| mem_cs_n_o | output | 1 | Memory chip select, active low |
| mem_we_n_o | output | 1 | Memory write enable, active low |
| mem_lb_n_o | output | 1 | Lower byte strobe, active low |
| mem_ub_n_o | output | 1 | Upper byte strobe, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_dq_o | output | 16 | Data driven toward the memory bus |
| mem_dq_oe_o | output | 1 | Enable of the data bus driver |

## Verification
The assertions check the following on every cycle:
- the ordering of write enable inside chip select, the strobes and the driver enable;
- the exact length of every write-enable pulse;
- the busy length and the done pulse at the end of every write;
- that the address stays still while busy;
- that the driver is off when idle.

Only the bench scenarios can show the rest. These are the following:
- that the right bytes land in memory and disabled lanes are untouched;
- that the data is on the bus long enough before the window closes;
- that a request in the done cycle is taken back to back;
- that requests during busy or with an empty mask leave the memory and pins alone.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETUP   = 3'd1,
    ST_PULSE   = 3'd2,
    ST_HOLD    = 3'd3,
    ST_RECOVER = 3'd4
  } wr_state_e;

  // ceiling of ns / clk_ns, never below one clock
  function automatic int ns_to_cycles(int ns, int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  // write-enable low time: pulse width, and address / data lead over the
  // window end minus the one setup cycle that precedes the pulse
  function automatic int pulse_cycles(int clk_ns, int wp_ns, int aw_ns, int dw_ns);
    int p;
    p = ns_to_cycles(wp_ns, clk_ns);
    if (ns_to_cycles(aw_ns, clk_ns) - 1 > p) p = ns_to_cycles(aw_ns, clk_ns) - 1;
    if (ns_to_cycles(dw_ns, clk_ns) - 1 > p) p = ns_to_cycles(dw_ns, clk_ns) - 1;
    if (p < 1) p = 1;
    return p;
  endfunction

  // recovery after the hold cycle: fill out the cycle time, and leave the
  // bus idle at least the output-enable recovery time
  function automatic int recover_cycles(int clk_ns, int wc_ns, int ow_ns, int p);
    int r;
    r = ns_to_cycles(wc_ns, clk_ns) - p - 2;
    if (ns_to_cycles(ow_ns, clk_ns) > r) r = ns_to_cycles(ow_ns, clk_ns);
    if (r < 1) r = 1;
    return r;
  endfunction

  function automatic int count_bits(int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/sram_wr_timer.sv
module sram_wr_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          expired_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/sram_wr_fsm.sv
module sram_wr_fsm
  import sram_wr_pkg::*;
#(
  parameter int P_CYC = 5,
  parameter int R_CYC = 1,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          expired_i,
  output wr_state_e     state_q_o,
  output wr_state_e     state_d_o,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output logic          finish_o
);

  localparam logic [CW-1:0] PULSE_LOAD = CW'(P_CYC - 1);
  localparam logic [CW-1:0] RECOV_LOAD = CW'(R_CYC - 1);

  wr_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (start_i)   st_d = ST_SETUP;
      ST_SETUP:                  st_d = ST_PULSE;
      ST_PULSE:   if (expired_i) st_d = ST_HOLD;
      ST_HOLD:                   st_d = ST_RECOVER;
      ST_RECOVER: if (expired_i) st_d = ST_IDLE;
      default:                   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // counts start on the edge that enters the timed state
  assign load_o     = (st_q == ST_SETUP) || (st_q == ST_HOLD);
  assign load_val_o = (st_q == ST_SETUP) ? PULSE_LOAD : RECOV_LOAD;
  assign finish_o   = (st_q == ST_RECOVER) && expired_i;
  assign state_q_o  = st_q;
  assign state_d_o  = st_d;

endmodule

// File: rtl/sram_wr_pins.sv
module sram_wr_pins
  import sram_wr_pkg::*;
#(
  parameter int AW    = 17,
  parameter int DW    = 16,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    data_i,
  input  logic [LANES-1:0] be_i,
  input  wr_state_e        state_d_i,
  input  logic             finish_i,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_dq_o,
  output logic             mem_dq_oe_o,
  output logic             mem_cs_n_o,
  output logic             mem_we_n_o,
  output logic [LANES-1:0] lane_n_o,
  output logic             done_o
);

  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    data_q;
  logic [LANES-1:0] be_q;
  logic [LANES-1:0] be_nx;
  logic [LANES-1:0] lane_n_q;
  logic             drive_d;
  logic             cs_n_q, we_n_q, dq_oe_q, done_q;

  // request fields held for the whole cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      be_q   <= '0;
    end else if (accept_i) begin
      addr_q <= addr_i;
      data_q <= data_i;
      be_q   <= be_i;
    end
  end

  assign be_nx   = accept_i ? be_i : be_q;
  assign drive_d = (state_d_i == ST_SETUP) || (state_d_i == ST_PULSE) ||
                   (state_d_i == ST_HOLD);

  // pins come straight from flops, decoded from the next state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      cs_n_q  <= !drive_d;
      we_n_q  <= (state_d_i != ST_PULSE);
      dq_oe_q <= drive_d;
      done_q  <= finish_i;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) lane_n_q[g] <= 1'b1;
      else        lane_n_q[g] <= !(drive_d && be_nx[g]);
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = data_q;
  assign mem_dq_oe_o = dq_oe_q;
  assign mem_cs_n_o  = cs_n_q;
  assign mem_we_n_o  = we_n_q;
  assign lane_n_o    = lane_n_q;
  assign done_o      = done_q;

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int AW      = 17,
  parameter int DW      = 16,
  parameter int CLK_NS  = 10,
  parameter int T_WP_NS = 45,
  parameter int T_AW_NS = 50,
  parameter int T_DW_NS = 25,
  parameter int T_WC_NS = 55,
  parameter int T_OW_NS = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   data_i,
  input  logic [DW/8-1:0] be_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic            mem_cs_n_o,
  output logic            mem_we_n_o,
  output logic            mem_lb_n_o,
  output logic            mem_ub_n_o,
  output logic            mem_oe_n_o,
  output logic [DW-1:0]   mem_dq_o,
  output logic            mem_dq_oe_o
);

  localparam int LANES     = DW / 8;
  localparam int PULSE_CYC = pulse_cycles(CLK_NS, T_WP_NS, T_AW_NS, T_DW_NS);
  localparam int RECOV_CYC = recover_cycles(CLK_NS, T_WC_NS, T_OW_NS, PULSE_CYC);
  localparam int TOTAL_CYC = 2 + PULSE_CYC + RECOV_CYC;
  localparam int CNT_W     = count_bits((PULSE_CYC > RECOV_CYC) ? PULSE_CYC : RECOV_CYC);

  // named internal events
  wr_state_e        state_q, state_d;
  logic             accept_w;
  logic             tmr_load_w;
  logic [CNT_W-1:0] tmr_val_w;
  logic             tmr_expired_w;
  logic             finish_w;
  logic [LANES-1:0] lane_n_w;

  assign accept_w = req_i && (be_i != '0) && (state_q == ST_IDLE);

  sram_wr_fsm #(
    .P_CYC(PULSE_CYC),
    .R_CYC(RECOV_CYC),
    .CW   (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (accept_w),
    .expired_i (tmr_expired_w),
    .state_q_o (state_q),
    .state_d_o (state_d),
    .load_o    (tmr_load_w),
    .load_val_o(tmr_val_w),
    .finish_o  (finish_w)
  );

  sram_wr_timer #(
    .CW(CNT_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (tmr_load_w),
    .load_val_i(tmr_val_w),
    .expired_o (tmr_expired_w)
  );

  sram_wr_pins #(
    .AW   (AW),
    .DW   (DW),
    .LANES(LANES)
  ) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept_i   (accept_w),
    .addr_i     (addr_i),
    .data_i     (data_i),
    .be_i       (be_i),
    .state_d_i  (state_d),
    .finish_i   (finish_w),
    .mem_addr_o (mem_addr_o),
    .mem_dq_o   (mem_dq_o),
    .mem_dq_oe_o(mem_dq_oe_o),
    .mem_cs_n_o (mem_cs_n_o),
    .mem_we_n_o (mem_we_n_o),
    .lane_n_o   (lane_n_w),
    .done_o     (done_o)
  );

  assign busy_o     = (state_q != ST_IDLE);
  assign mem_lb_n_o = lane_n_w[0];
  assign mem_ub_n_o = lane_n_w[LANES-1];
  assign mem_oe_n_o = 1'b1;

endmodule

// File: rtl/sram_wr_seq_chk.sv
module sram_wr_seq_chk #(
  parameter int AW      = 17,
  parameter int P_CYC   = 5,
  parameter int TOT_CYC = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          accept_w,
  input logic          busy_o,
  input logic          done_o,
  input logic          mem_cs_n_o,
  input logic          mem_we_n_o,
  input logic          mem_lb_n_o,
  input logic          mem_ub_n_o,
  input logic          mem_dq_oe_o,
  input logic [AW-1:0] mem_addr_o
);

  int low_run;
  int busy_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_run  <= 0;
      busy_run <= 0;
    end else begin
      low_run  <= mem_we_n_o ? 0 : low_run + 1;
      busy_run <= busy_o ? busy_run + 1 : 0;
    end
  end

  p_accept_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> busy_o && !mem_cs_n_o && mem_we_n_o && mem_dq_oe_o);

  p_pulse_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n_o) |-> (low_run == P_CYC));

  p_we_inside_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n_o |-> !mem_cs_n_o && (!mem_lb_n_o || !mem_ub_n_o) && mem_dq_oe_o);

  p_we_falls_late_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n_o) |-> $past(!mem_cs_n_o) && $past(mem_dq_oe_o));

  p_we_rises_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n_o) |-> !mem_cs_n_o && mem_dq_oe_o);

  p_drive_in_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe_o |-> !mem_cs_n_o);

  p_addr_still_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> $stable(mem_addr_o));

  p_cycle_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (busy_run == TOT_CYC) && done_o);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

bind sram_wr_seq sram_wr_seq_chk #(
  .AW     (AW),
  .P_CYC  (PULSE_CYC),
  .TOT_CYC(TOTAL_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .accept_w   (accept_w),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .mem_cs_n_o (mem_cs_n_o),
  .mem_we_n_o (mem_we_n_o),
  .mem_lb_n_o (mem_lb_n_o),
  .mem_ub_n_o (mem_ub_n_o),
  .mem_dq_oe_o(mem_dq_oe_o),
  .mem_addr_o (mem_addr_o)
);

// File: tb/tb_sram_wr_seq.sv
`timescale 1ns/1ps
module tb_sram_wr_seq;

  localparam int CLK_PERIOD = 10;
  localparam int T_WP = 45, T_AW = 50, T_DW = 25, T_WC = 55, T_OW = 5;

  function automatic int up_div(int a, int b);
    return (a + b - 1) / b;
  endfunction
  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int P_EXP    = imax(imax(up_div(T_WP, CLK_PERIOD), up_div(T_AW, CLK_PERIOD) - 1),
                                 imax(up_div(T_DW, CLK_PERIOD) - 1, 1));
  localparam int DSET_EXP = up_div(T_DW, CLK_PERIOD);
  localparam int ASET_EXP = up_div(T_AW, CLK_PERIOD);
  localparam int TOT_EXP  = imax(up_div(T_WC, CLK_PERIOD),
                                 2 + P_EXP + imax(up_div(T_OW, CLK_PERIOD), 1));

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req;
  logic [16:0] addr;
  logic [15:0] data;
  logic [1:0]  be;
  logic        busy, done;
  logic [16:0] m_addr;
  logic        cs_n, we_n, lb_n, ub_n, oe_n;
  logic [15:0] dq;
  logic        dq_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_wr_seq #(
    .CLK_NS (CLK_PERIOD),
    .T_WP_NS(T_WP),
    .T_AW_NS(T_AW),
    .T_DW_NS(T_DW),
    .T_WC_NS(T_WC),
    .T_OW_NS(T_OW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .addr_i(addr), .data_i(data), .be_i(be),
    .busy_o(busy), .done_o(done), .mem_addr_o(m_addr), .mem_cs_n_o(cs_n),
    .mem_we_n_o(we_n), .mem_lb_n_o(lb_n), .mem_ub_n_o(ub_n), .mem_oe_n_o(oe_n),
    .mem_dq_o(dq), .mem_dq_oe_o(dq_oe)
  );

  typedef struct {
    logic [16:0] a;
    logic [15:0] d;
    logic [1:0]  be;
  } item_t;

  item_t       exp_q[$];
  logic [15:0] model_mem[int];
  logic [15:0] exp_mem[int];
  int checks = 0, fails = 0;
  int oe_bad = 0, done_bad = 0;
  bit finished = 0;

  function automatic logic [15:0] rd_model(int a);
    return model_mem.exists(a) ? model_mem[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] rd_exp(int a);
    return exp_mem.exists(a) ? exp_mem[a] : 16'h0000;
  endfunction

  task automatic check(input bit ok, input string req_tag, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req_tag, what, act, expv);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // driver: called at a negedge; pushes the expected item
  task automatic do_write(input logic [16:0] a, input logic [15:0] d, input logic [1:0] m);
    logic [15:0] w;
    item_t it;
    while (busy) @(negedge clk);
    req = 1'b1; addr = a; data = d; be = m;
    it.a = a; it.d = d; it.be = m;
    exp_q.push_back(it);
    w = rd_exp(int'(a));
    if (m[0]) w[7:0]  = d[7:0];
    if (m[1]) w[15:8] = d[15:8];
    exp_mem[int'(a)] = w;
    @(negedge clk);
    req = 1'b0;
    check(busy === 1'b1, "R2", "busy after accept", int'(busy), 1);
  endtask

  task automatic wait_idle();
    while (busy || exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  int  low_cnt = 0, dset_cnt = 0, busy_cnt = 0;
  bit  wend = 0;
  logic prev_we = 1'b1, prev_done = 1'b0, prev_busy = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      item_t it;
      logic [15:0] w;
      if (oe_n !== 1'b1) oe_bad++;
      if (done && prev_done) done_bad++;
      if (busy && !prev_busy && exp_q.size() != 0) begin
        check(cs_n === 1'b0 && we_n === 1'b1, "R2", "setup cycle cs_n/we_n",
              int'({cs_n, we_n}), 1);
        check(lb_n === !exp_q[0].be[0] && ub_n === !exp_q[0].be[1], "R2",
              "lane strobes {ub_n,lb_n}", int'({ub_n, lb_n}), int'(~exp_q[0].be));
      end
      if (prev_we === 1'b0 && we_n === 1'b1) begin
        wend = 1;
        if (cs_n === 1'b0) begin
          w = rd_model(int'(m_addr));
          if (!lb_n) w[7:0]  = dq[7:0];
          if (!ub_n) w[15:8] = dq[15:8];
          model_mem[int'(m_addr)] = w;
        end
      end
      if (busy) begin
        busy_cnt++;
        if (!we_n) low_cnt++;
        if (dq_oe && !wend) dset_cnt++;
      end
      if (done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "done with no accepted request", 1, 0);
        end else begin
          it = exp_q.pop_front();
          check(low_cnt == P_EXP, "R3", "write pulse cycles", low_cnt, P_EXP);
          check(dset_cnt >= DSET_EXP && dset_cnt >= ASET_EXP, "R4",
                "data/address lead cycles", dset_cnt, imax(DSET_EXP, ASET_EXP));
          check(busy_cnt == TOT_EXP, "R6", "busy cycles", busy_cnt, TOT_EXP);
          check(rd_model(int'(it.a)) === rd_exp(int'(it.a)), "R2", "memory word",
                int'(rd_model(int'(it.a))), int'(rd_exp(int'(it.a))));
        end
        low_cnt = 0; dset_cnt = 0; busy_cnt = 0; wend = 0;
      end
      prev_we = we_n; prev_done = done; prev_busy = busy;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    report();
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; addr = '0; data = '0; be = '0;
    repeat (3) @(negedge clk);
    // R1: during reset
    check({cs_n, we_n, lb_n, ub_n, oe_n} === 5'b11111, "R1", "pins in reset",
          int'({cs_n, we_n, lb_n, ub_n, oe_n}), 5'h1f);
    check(dq_oe === 1'b0 && busy === 1'b0 && done === 1'b0, "R1", "flags in reset",
          int'({dq_oe, busy, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({cs_n, we_n, lb_n, ub_n, oe_n} === 5'b11111 && dq_oe === 1'b0 && busy === 1'b0,
          "R1", "idle after reset", int'({cs_n, we_n, lb_n, ub_n, oe_n, dq_oe, busy}), 7'h7c);

    // R2: both lanes, then lower only, then upper only
    do_write(17'h00010, 16'hA5C3, 2'b11);
    wait_idle();
    do_write(17'h00010, 16'h1234, 2'b01);
    wait_idle();
    check(rd_model(16) === 16'hA534, "R2", "lower-only keeps upper",
          int'(rd_model(16)), 16'hA534);
    do_write(17'h1FFFF, 16'hBEEF, 2'b10);
    wait_idle();
    check(rd_model(17'h1FFFF) === 16'hBE00, "R2", "upper-only keeps lower",
          int'(rd_model(17'h1FFFF)), 16'hBE00);

    // R7: back-to-back, next request in the done cycle
    do_write(17'h00100, 16'h0F0F, 2'b11);
    while (!done) @(negedge clk);
    check(done === 1'b1 && busy === 1'b0, "R7", "done cycle has busy low",
          int'({done, busy}), 2);
    do_write(17'h00101, 16'hF0F0, 2'b11);
    wait_idle();

    // R8: request while busy is ignored
    do_write(17'h00200, 16'h5555, 2'b11);
    @(negedge clk);
    req = 1'b1; addr = 17'h00300; data = 16'hDEAD; be = 2'b11;
    @(negedge clk);
    req = 1'b0;
    check(m_addr === 17'h00200, "R8", "address kept during busy", int'(m_addr), 17'h00200);
    wait_idle();
    check(rd_model(17'h00300) === 16'h0000, "R8", "busy-time request not written",
          int'(rd_model(17'h00300)), 0);
    check(busy === 1'b0, "R8", "no extra cycle after ignored request", int'(busy), 0);

    // R8: empty lane mask is ignored
    req = 1'b1; addr = 17'h00400; data = 16'h7777; be = 2'b00;
    @(negedge clk);
    req = 1'b0;
    check(busy === 1'b0 && cs_n === 1'b1, "R8", "empty mask not accepted",
          int'({busy, cs_n}), 1);
    repeat (TOT_EXP + 2) @(negedge clk);
    check(rd_model(17'h00400) === 16'h0000 && done_bad == 0, "R8", "empty mask no write",
          int'(rd_model(17'h00400)), 0);

    // R5: driver off when idle; R9 / R7 summaries
    check(dq_oe === 1'b0, "R5", "driver off when idle", int'(dq_oe), 0);
    check(oe_bad == 0, "R9", "output enable low cycles", oe_bad, 0);
    check(done_bad == 0, "R7", "multi-cycle done pulses", done_bad, 0);
    check(exp_q.size() == 0, "R6", "writes left without done", exp_q.size(), 0);
    report();
  end

endmodule